// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Tracker

This block follows the command stream sent to a four-bank SDRAM and keeps, for every bank, whether it holds an open row, is waiting on an automatic close, or is recovering from a close. From that state it tells the controller, cycle by cycle and per bank, which commands would be legal right now: opening a row, issuing a read or write, or closing the row. It also reports when every bank is idle, which is the condition for refresh and mode-setting commands.

Timing is supplied as picosecond values plus the clock period, and the block rounds each one up to a whole number of cycles. Closing a row is held back until the row has been open for the minimum open time. A closed bank cannot be reopened until the recovery time has elapsed. A read or write that requests an automatic close locks the bank until it is idle again. The close then starts at the later of two events: the end of the burst, or the minimum open time being met. A bank that stays open too long first raises a warning a set margin ahead of the limit, and then raises a violation flag at the limit. A command that breaks any of these rules does not change any bank state, and it is reported by a one-cycle error pulse.

Top module: `sdram_bank_guard`

## Requirements
- R1: Commands are decoded with `cs_n` low from {`ras_n`,`cas_n`,`we_n`}: 011 open row, 101 read, 100 write, 010 close, 001 refresh, 000 mode set. `cs_n` high or any other code is a no-op. An open-row command to an idle bank sets `bank_open` for that bank and clears its `act_ok`, both from the next cycle. `ba` selects the bank.
- R2: A close command with `a10` low closes only the bank selected by `ba`. `bank_open` for that bank falls in the cycle after the command.
- R3: A close command with `a10` high closes every bank together. It is accepted only when `pre_ok` is high for every bank.
- R4: Recovery lasts TRP_CYC = ceil(T_RP_PS / CLK_PS) cycles, with a minimum of 2. A bank closed by a command in cycle p shows `act_ok` high from cycle p+TRP_CYC, and may be reopened by a command in that cycle.
- R5: The minimum open time is TRAS_CYC = ceil(T_RAS_MIN_PS / CLK_PS) cycles. After an open-row command in cycle t, `pre_ok` for that bank is low until cycle t+TRAS_CYC.
- R6: A read or write with `a10` high locks the bank: `rw_ok`, `pre_ok` and `act_ok` are all low. The internal close takes effect at the later of these two points: the command cycle plus BURST_CYC, and the open-row cycle plus TRAS_CYC. Recovery per R4 follows.
- R7: `ras_viol` is high while a bank has been open for at least TRAS_MAX_CYC cycles.
- R8: `ras_warn` is high while a bank has been open for at least TRAS_MAX_CYC - WARN_MARGIN cycles. Both flags are low once the bank is closed.
- R9: Refresh and mode-set commands are legal only while `all_idle` is high. `all_idle` is high exactly when every bank shows `act_ok`.
- R10: An illegal command changes no bank state, and `cmd_err` goes high for exactly the cycle after it. Illegal commands are: an open-row command to a bank that is not idle, a read or write to a bank without `rw_ok`, a close without the needed `pre_ok`, and a refresh or mode set while any bank is not idle.
- R11: After reset, every bank is idle: `act_ok`, `pre_ok` and `all_idle` are high, while `bank_open`, `rw_ok`, `ras_warn`, `ras_viol` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select of the observed command, active low |
| ras_n | input | 1 | Row strobe of the observed command |
| cas_n | input | 1 | Column strobe of the observed command |
| we_n | input | 1 | Write enable of the observed command |
| ba | input | $clog2(NUM_BANKS) | Bank address |
| a10 | input | 1 | All-banks / automatic-close qualifier |
| bank_open | output | NUM_BANKS | Bank holds an open row (including pending automatic close) |
| act_ok | output | NUM_BANKS | Bank is idle and may be opened |
| pre_ok | output | NUM_BANKS | A close command to the bank is legal |
| rw_ok | output | NUM_BANKS | A read or write to the bank is legal |
| ras_warn | output | NUM_BANKS | Open time has reached the warning point |
| ras_viol | output | NUM_BANKS | Open time has reached the maximum |
| all_idle | output | 1 | Every bank is idle |
| cmd_err | output | 1 | Previous command was illegal and ignored |

## Verification
The bench builds the tracker with an 8000 ps period, 42000 ps minimum open time and 18000 ps recovery. These round up to 6 and 3 cycles, so both rounding paths carry a fractional remainder. The maximum open time is set to 40 cycles with a 5-cycle margin, so the warning and violation edges are reached within about forty cycles. A burst of 4 cycles is shorter than the open-time minimum when the automatic close comes right after opening, and it dominates when the close comes late, so both arms of the close-start rule are observed.

// File: rtl/bank_guard_pkg.sv
`timescale 1ns/1ps
package bank_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_OPEN,
    BS_APWAIT,
    BS_RECOV
  } bank_st_e;

  // whole cycles covering a time span, rounded up
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int at_least(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  // bits needed to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // open-time count at which the early warning starts
  function automatic int warn_point(input int max_cyc, input int margin);
    return (margin >= max_cyc) ? 0 : max_cyc - margin;
  endfunction

endpackage

// File: rtl/bg_cmd_decode.sv
`timescale 1ns/1ps
module bg_cmd_decode
  import bank_guard_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/bg_bank_fsm.sv
`timescale 1ns/1ps
module bg_bank_fsm
  import bank_guard_pkg::*;
#(
  parameter int TRAS_CYC     = 6,
  parameter int TRP_CYC      = 3,
  parameter int TRAS_MAX_CYC = 13334,
  parameter int WARN_AT      = 12834,
  parameter int BURST_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic pre_go,
  input  logic ap_go,
  output logic open_o,
  output logic act_ok_o,
  output logic pre_ok_o,
  output logic rw_ok_o,
  output logic warn_o,
  output logic viol_o,
  output logic ap_fire_o,
  output logic rp_done_o
);

  localparam int CNT_W = cnt_width(TRAS_MAX_CYC);
  localparam int RP_W  = cnt_width(TRP_CYC);
  localparam int BST_W = cnt_width(BURST_CYC);

  bank_st_e         state_q;
  logic [CNT_W-1:0] act_cnt;
  logic [RP_W-1:0]  rp_cnt;
  logic [BST_W-1:0] bst_cnt;

  logic is_open, tras_met, ap_fire, rp_done, cnt_room;

  assign is_open  = (state_q == BS_OPEN) || (state_q == BS_APWAIT);
  assign tras_met = act_cnt >= CNT_W'(TRAS_CYC);
  assign cnt_room = act_cnt < CNT_W'(TRAS_MAX_CYC);
  // internal close of an automatic-precharge access
  assign ap_fire  = (state_q == BS_APWAIT) && (bst_cnt >= BST_W'(BURST_CYC)) && tras_met;
  // last recovery cycle
  assign rp_done  = (state_q == BS_RECOV) && (rp_cnt >= RP_W'(TRP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      act_cnt <= '0;
      rp_cnt  <= '0;
      bst_cnt <= '0;
    end else begin
      case (state_q)
        BS_IDLE: begin
          if (act_go) begin
            state_q <= BS_OPEN;
            act_cnt <= CNT_W'(1);
          end
        end
        BS_OPEN: begin
          if (cnt_room) act_cnt <= act_cnt + CNT_W'(1);
          if (pre_go) begin
            state_q <= BS_RECOV;
            rp_cnt  <= RP_W'(1);
          end else if (ap_go) begin
            state_q <= BS_APWAIT;
            bst_cnt <= BST_W'(1);
          end
        end
        BS_APWAIT: begin
          if (cnt_room) act_cnt <= act_cnt + CNT_W'(1);
          if (bst_cnt < BST_W'(BURST_CYC)) bst_cnt <= bst_cnt + BST_W'(1);
          if (ap_fire) begin
            state_q <= BS_RECOV;
            rp_cnt  <= RP_W'(1);
          end
        end
        BS_RECOV: begin
          if (rp_done) begin
            state_q <= BS_IDLE;
            act_cnt <= '0;
            bst_cnt <= '0;
          end else begin
            rp_cnt <= rp_cnt + RP_W'(1);
          end
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  assign open_o    = is_open;
  assign act_ok_o  = (state_q == BS_IDLE);
  assign rw_ok_o   = (state_q == BS_OPEN);
  assign pre_ok_o  = (state_q == BS_IDLE) || (state_q == BS_RECOV) ||
                     ((state_q == BS_OPEN) && tras_met);
  assign warn_o    = is_open && (act_cnt >= CNT_W'(WARN_AT));
  assign viol_o    = is_open && !cnt_room;
  assign ap_fire_o = ap_fire;
  assign rp_done_o = rp_done;

endmodule

// File: rtl/sdram_bank_guard.sv
`timescale 1ns/1ps
module sdram_bank_guard
  import bank_guard_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int CLK_PS       = 7500,
  parameter int T_RAS_MIN_PS = 45000,
  parameter int T_RP_PS      = 20000,
  parameter int TRAS_MAX_CYC = 13334,
  parameter int WARN_MARGIN  = 500,
  parameter int BURST_CYC    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic                         a10,
  output logic [NUM_BANKS-1:0]         bank_open,
  output logic [NUM_BANKS-1:0]         act_ok,
  output logic [NUM_BANKS-1:0]         pre_ok,
  output logic [NUM_BANKS-1:0]         rw_ok,
  output logic [NUM_BANKS-1:0]         ras_warn,
  output logic [NUM_BANKS-1:0]         ras_viol,
  output logic                         all_idle,
  output logic                         cmd_err
);

  localparam int BA_W     = $clog2(NUM_BANKS);
  localparam int TRAS_CYC = ceil_div(T_RAS_MIN_PS, CLK_PS);
  localparam int TRP_CYC  = at_least(ceil_div(T_RP_PS, CLK_PS), 2);
  localparam int WARN_AT  = warn_point(TRAS_MAX_CYC, WARN_MARGIN);

  cmd_e                 cmd_kind;
  logic                 cmd_legal;
  logic                 all_pre_ok;
  logic [NUM_BANKS-1:0] act_go_v, pre_go_v, ap_go_v;
  logic [NUM_BANKS-1:0] ap_fire_v, rp_done_v;

  bg_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd_kind)
  );

  assign all_pre_ok = &pre_ok;
  assign all_idle   = &act_ok;

  always_comb begin
    case (cmd_kind)
      CMD_ACT:         cmd_legal = act_ok[ba];
      CMD_RD, CMD_WR:  cmd_legal = rw_ok[ba];
      CMD_PRE:         cmd_legal = a10 ? all_pre_ok : pre_ok[ba];
      CMD_REF, CMD_MRS: cmd_legal = all_idle;
      default:         cmd_legal = 1'b1;
    endcase
  end

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(gi));
    assign act_go_v[gi] = (cmd_kind == CMD_ACT) && hit && act_ok[gi];
    assign pre_go_v[gi] = (cmd_kind == CMD_PRE) && cmd_legal && (a10 || hit);
    assign ap_go_v[gi]  = ((cmd_kind == CMD_RD) || (cmd_kind == CMD_WR)) &&
                          a10 && hit && rw_ok[gi];

    bg_bank_fsm #(
      .TRAS_CYC     (TRAS_CYC),
      .TRP_CYC      (TRP_CYC),
      .TRAS_MAX_CYC (TRAS_MAX_CYC),
      .WARN_AT      (WARN_AT),
      .BURST_CYC    (BURST_CYC)
    ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_go    (act_go_v[gi]),
      .pre_go    (pre_go_v[gi]),
      .ap_go     (ap_go_v[gi]),
      .open_o    (bank_open[gi]),
      .act_ok_o  (act_ok[gi]),
      .pre_ok_o  (pre_ok[gi]),
      .rw_ok_o   (rw_ok[gi]),
      .warn_o    (ras_warn[gi]),
      .viol_o    (ras_viol[gi]),
      .ap_fire_o (ap_fire_v[gi]),
      .rp_done_o (rp_done_v[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= !cmd_legal;
  end

endmodule

// File: rtl/sdram_bank_guard_chk.sv
`timescale 1ns/1ps
module sdram_bank_guard_chk
  import bank_guard_pkg::*;
#(
  parameter int NB       = 4,
  parameter int TRAS_CYC = 6,
  parameter int TRP_CYC  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input cmd_e                  cmd,
  input logic [$clog2(NB)-1:0] ba,
  input logic                  a10,
  input logic [NB-1:0]         bank_open,
  input logic [NB-1:0]         act_ok,
  input logic [NB-1:0]         pre_ok,
  input logic [NB-1:0]         rw_ok,
  input logic [NB-1:0]         ras_warn,
  input logic [NB-1:0]         ras_viol,
  input logic                  all_idle,
  input logic                  cmd_err,
  input logic [NB-1:0]         ap_fire,
  input logic [NB-1:0]         rp_done
);

  // R10
  illegal_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && !act_ok[ba]) |=> cmd_err);

  // R9
  mode_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_REF || cmd == CMD_MRS) && !all_idle) |=> cmd_err);

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && a10 && (&pre_ok)) |=> (bank_open == '0));

  for (genvar gi = 0; gi < NB; gi++) begin : g_b
    logic [15:0] open_len;
    logic [15:0] rec_len;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_len <= '0;
        rec_len  <= '0;
      end else begin
        if (!bank_open[gi])           open_len <= '0;
        else if (open_len != 16'hFFFF) open_len <= open_len + 16'd1;
        if (bank_open[gi])             rec_len <= '0;
        else if (rec_len != 16'hFFFF)  rec_len <= rec_len + 16'd1;
      end
    end

    // R1
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT && ba == ($clog2(NB))'(gi) && act_ok[gi]) |=> (bank_open[gi] && !act_ok[gi]));

    // R5
    tras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_open[gi]) |-> (open_len >= 16'(TRAS_CYC)));

    // R4
    trp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_ok[gi]) |-> ((rec_len == 16'(TRP_CYC - 1)) && $past(rp_done[gi])));

    // R6
    ap_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ap_fire[gi] |-> (!rw_ok[gi] && !act_ok[gi] && bank_open[gi]));

    // R8
    warn_before_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ras_viol[gi] |-> ras_warn[gi]);
  end

endmodule

bind sdram_bank_guard sdram_bank_guard_chk #(
  .NB       (NUM_BANKS),
  .TRAS_CYC (TRAS_CYC),
  .TRP_CYC  (TRP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       (cmd_kind),
  .ba        (ba),
  .a10       (a10),
  .bank_open (bank_open),
  .act_ok    (act_ok),
  .pre_ok    (pre_ok),
  .rw_ok     (rw_ok),
  .ras_warn  (ras_warn),
  .ras_viol  (ras_viol),
  .all_idle  (all_idle),
  .cmd_err   (cmd_err),
  .ap_fire   (ap_fire_v),
  .rp_done   (rp_done_v)
);

// File: tb/sdram_bank_guard_test.sv
`timescale 1ns/1ps
module sdram_bank_guard_test;

  localparam int NB      = 4;
  localparam int P_CLK   = 8000;
  localparam int P_RAS   = 42000;
  localparam int P_RP    = 18000;
  localparam int P_MAX   = 40;
  localparam int P_MARG  = 5;
  localparam int P_BURST = 4;

  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  localparam int K_ACT = 0, K_PRE = 1, K_RW = 2, K_OPEN = 3, K_WARN = 4,
                 K_VIOL = 5, K_IDLE = 6, K_ERR = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [NB-1:0] bank_open, act_ok, pre_ok, rw_ok, ras_warn, ras_viol;
  logic all_idle, cmd_err;

  always #4 clk = ~clk;

  sdram_bank_guard #(
    .NUM_BANKS    (NB),
    .CLK_PS       (P_CLK),
    .T_RAS_MIN_PS (P_RAS),
    .T_RP_PS      (P_RP),
    .TRAS_MAX_CYC (P_MAX),
    .WARN_MARGIN  (P_MARG),
    .BURST_CYC    (P_BURST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .bank_open(bank_open), .act_ok(act_ok), .pre_ok(pre_ok),
    .rw_ok(rw_ok), .ras_warn(ras_warn), .ras_viol(ras_viol), .all_idle(all_idle),
    .cmd_err(cmd_err)
  );

  typedef struct {
    int    at;
    int    kind;
    int    bank;
    logic  val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic int up_div(input int a, input int b);
    int r;
    r = a / b;
    if (r * b < a) r = r + 1;
    return r;
  endfunction

  int TR, TP;
  initial begin
    TR = up_div(P_RAS, P_CLK);
    TP = up_div(P_RP, P_CLK);
    if (TP < 2) TP = 2;
  end

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic observe(input int kind, input int b);
    case (kind)
      K_ACT:  return act_ok[b];
      K_PRE:  return pre_ok[b];
      K_RW:   return rw_ok[b];
      K_OPEN: return bank_open[b];
      K_WARN: return ras_warn[b];
      K_VIOL: return ras_viol[b];
      K_IDLE: return all_idle;
      default: return cmd_err;
    endcase
  endfunction

  // monitor: pops due items and compares
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int k = q.size() - 1; k >= 0; k--) begin
        if (q[k].at == cyc) begin
          logic got;
          got = observe(q[k].kind, q[k].bank);
          checks++;
          if (got !== q[k].val) begin
            errors++;
            $display("FAIL %s cyc=%0d kind=%0d bank=%0d actual=%b expected=%b",
                     q[k].req, cyc, q[k].kind, q[k].bank, got, q[k].val);
          end
          q.delete(k);
        end
      end
    end
  end

  task automatic expect_at(input int at, input int kind, input int b, input logic v, input string req);
    exp_t e;
    e.at = at; e.kind = kind; e.bank = b; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic put(input logic [2:0] rcw, input int b, input logic hi);
    cs_n = (rcw == C_NOP);
    {ras_n, cas_n, we_n} = rcw;
    ba = b[1:0];
    a10 = hi;
  endtask

  // drives nops until the command lands on clock edge e
  task automatic issue(input int e, input logic [2:0] rcw, input int b, input logic hi);
    forever begin
      @(negedge clk);
      if (cyc + 1 >= e) begin
        put(rcw, b, hi);
        break;
      end
      put(C_NOP, 0, 1'b0);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int t, p, s, r, q0;
    // R11 reset state
    for (int b = 0; b < NB; b++) begin
      expect_at(1, K_ACT, b, 1'b1, "R11");
      expect_at(1, K_PRE, b, 1'b1, "R11");
      expect_at(1, K_OPEN, b, 1'b0, "R11");
      expect_at(1, K_RW, b, 1'b0, "R11");
      expect_at(1, K_WARN, b, 1'b0, "R11");
      expect_at(1, K_VIOL, b, 1'b0, "R11");
    end
    expect_at(1, K_IDLE, 0, 1'b1, "R11");
    expect_at(1, K_ERR, 0, 1'b0, "R11");
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 R2 R4 R5: open, close at minimum, reopen after recovery
    t = cyc + 3;
    issue(t, C_ACT, 0, 1'b0);
    expect_at(t, K_OPEN, 0, 1'b1, "R1");
    expect_at(t, K_ACT, 0, 1'b0, "R1");
    expect_at(t, K_RW, 0, 1'b1, "R1");
    expect_at(t, K_IDLE, 0, 1'b0, "R9");
    expect_at(t, K_ERR, 0, 1'b0, "R1");
    expect_at(t + TR - 2, K_PRE, 0, 1'b0, "R5");
    expect_at(t + TR - 1, K_PRE, 0, 1'b1, "R5");
    p = t + TR;
    issue(p, C_PRE, 0, 1'b0);
    expect_at(p, K_OPEN, 0, 1'b0, "R2");
    expect_at(p, K_ERR, 0, 1'b0, "R2");
    expect_at(p + TP - 2, K_ACT, 0, 1'b0, "R4");
    expect_at(p + TP - 1, K_ACT, 0, 1'b1, "R4");
    expect_at(p + TP - 1, K_IDLE, 0, 1'b1, "R9");
    issue(p + TP, C_ACT, 0, 1'b0);
    expect_at(p + TP, K_OPEN, 0, 1'b1, "R4");
    expect_at(p + TP, K_ERR, 0, 1'b0, "R4");
    issue(p + TP + TR, C_PRE, 0, 1'b0);

    // R10: early close and reopen of an open bank are ignored
    t = cyc + 3;
    issue(t, C_ACT, 3, 1'b0);
    issue(t + 2, C_PRE, 3, 1'b0);
    expect_at(t + 2, K_ERR, 0, 1'b1, "R10");
    expect_at(t + 2, K_OPEN, 3, 1'b1, "R10");
    expect_at(t + 3, K_ERR, 0, 1'b0, "R10");
    issue(t + 4, C_ACT, 3, 1'b0);
    expect_at(t + 4, K_ERR, 0, 1'b1, "R10");
    expect_at(t + 4, K_OPEN, 3, 1'b1, "R10");
    issue(t + 5, C_RD, 3, 1'b0);
    expect_at(t + 5, K_ERR, 0, 1'b0, "R10");
    expect_at(t + 5, K_RW, 3, 1'b1, "R10");
    issue(t + TR, C_PRE, 3, 1'b0);

    // R3 R9: close-all, refresh and mode set gating
    t = cyc + TP + 3;
    issue(t, C_ACT, 0, 1'b0);
    issue(t + 1, C_ACT, 1, 1'b0);
    issue(t + 3, C_PRE, 0, 1'b1);
    expect_at(t + 3, K_ERR, 0, 1'b1, "R3");
    expect_at(t + 3, K_OPEN, 0, 1'b1, "R3");
    expect_at(t + 3, K_OPEN, 1, 1'b1, "R3");
    q0 = t + 1 + TR;
    issue(q0, C_PRE, 2, 1'b1);
    expect_at(q0, K_OPEN, 0, 1'b0, "R3");
    expect_at(q0, K_OPEN, 1, 1'b0, "R3");
    expect_at(q0, K_ERR, 0, 1'b0, "R3");
    expect_at(q0, K_ACT, 2, 1'b1, "R3");
    issue(q0 + 1, C_REF, 0, 1'b0);
    expect_at(q0 + 1, K_ERR, 0, 1'b1, "R9");
    expect_at(q0 + TP - 2, K_IDLE, 0, 1'b0, "R9");
    expect_at(q0 + TP - 1, K_IDLE, 0, 1'b1, "R9");
    expect_at(q0 + TP - 1, K_ACT, 1, 1'b1, "R4");
    issue(q0 + TP, C_REF, 0, 1'b0);
    expect_at(q0 + TP, K_ERR, 0, 1'b0, "R9");
    issue(q0 + TP + 1, C_MRS, 0, 1'b0);
    expect_at(q0 + TP + 1, K_ERR, 0, 1'b0, "R9");

    // R6: automatic close right after opening (open-time limit dominates)
    t = cyc + 3;
    issue(t, C_ACT, 2, 1'b0);
    issue(t + 1, C_RD, 2, 1'b1);
    expect_at(t + 1, K_RW, 2, 1'b0, "R6");
    expect_at(t + 1, K_PRE, 2, 1'b0, "R6");
    expect_at(t + 1, K_ACT, 2, 1'b0, "R6");
    issue(t + 3, C_PRE, 2, 1'b0);
    expect_at(t + 3, K_ERR, 0, 1'b1, "R6");
    issue(t + 4, C_RD, 2, 1'b0);
    expect_at(t + 4, K_ERR, 0, 1'b1, "R6");
    s = (t + 1 + P_BURST > t + TR) ? t + 1 + P_BURST : t + TR;
    expect_at(s - 1, K_OPEN, 2, 1'b1, "R6");
    expect_at(s, K_OPEN, 2, 1'b0, "R6");
    expect_at(s + TP - 2, K_ACT, 2, 1'b0, "R6");
    expect_at(s + TP - 1, K_ACT, 2, 1'b1, "R6");

    // R6: automatic close late (burst dominates)
    t = s + TP + 2;
    issue(t, C_ACT, 1, 1'b0);
    r = t + TR + 2;
    issue(r, C_WR, 1, 1'b1);
    expect_at(r, K_ERR, 0, 1'b0, "R6");
    s = (r + P_BURST > t + TR) ? r + P_BURST : t + TR;
    expect_at(s - 1, K_OPEN, 1, 1'b1, "R6");
    expect_at(s, K_OPEN, 1, 1'b0, "R6");
    expect_at(s + TP - 2, K_ACT, 1, 1'b0, "R6");
    expect_at(s + TP - 1, K_ACT, 1, 1'b1, "R6");

    // R7 R8: long open time
    t = s + TP + 2;
    issue(t, C_ACT, 3, 1'b0);
    expect_at(t + (P_MAX - P_MARG) - 2, K_WARN, 3, 1'b0, "R8");
    expect_at(t + (P_MAX - P_MARG) - 1, K_WARN, 3, 1'b1, "R8");
    expect_at(t + P_MAX - 2, K_VIOL, 3, 1'b0, "R7");
    expect_at(t + P_MAX - 1, K_VIOL, 3, 1'b1, "R7");
    expect_at(t + P_MAX - 1, K_OPEN, 3, 1'b1, "R7");
    p = t + P_MAX + 1;
    issue(p, C_PRE, 3, 1'b0);
    expect_at(p, K_OPEN, 3, 1'b0, "R7");
    expect_at(p, K_VIOL, 3, 1'b0, "R7");
    expect_at(p, K_WARN, 3, 1'b0, "R8");

    for (int w = 0; w < 200 && q.size() > 0; w++) begin
      @(negedge clk);
      put(C_NOP, 0, 1'b0);
    end
    repeat (2) @(negedge clk);
    if (q.size() > 0) begin
      errors += q.size();
      $display("FAIL %s pending=%0d actual=unchecked expected=checked", q[0].req, q.size());
    end
    finish_run();
  end

endmodule